// File: doc/BRIEF.md
# Background Tile Pixel Fetcher

This block produces the background pixels of one scanline on a tile-based display. A one-cycle `line_start` pulse captures the line number, the two scroll offsets, the two addressing selects and the palette byte. The block then walks across the 256x256 background plane, which is built from 8x8 tiles. For every tile it reads the tile index from a 32x32 map, then reads the two bit-plane bytes of the row it needs. The two bytes go into a pair of shift registers that move together. Each 2-bit colour that leaves them is translated through the palette and offered on a valid/ready pixel stream.

Video RAM is reached through a plain read port: the address and `vram_rd` are presented in one cycle, and `vram_data` holds that byte in the following cycle. Fine horizontal scroll is handled by shifting out and dropping the first (scroll_x mod 8) pixels of the first tile. Exactly 160 pixels are then delivered, and `line_done` stays high until the next `line_start`.

The pixel stream follows the usual back-pressure rules. While `pix_valid` is high and `pix_ready` is low, the pixel and its valid stay unchanged. A pixel is consumed at a clock edge where both are high. Dropped scroll pixels do not wait for `pix_ready`.

Top module: `tile_pixel_fetcher`

## Requirements
- R1: After reset, `pix_valid`, `vram_rd` and `line_done` are all 0 until the first `line_start`.
- R2: Map reads go to base + 32*map_row + map_col. The base is 0x9800 when `map_hi_sel`=0 and 0x9C00 when it is 1. map_row = ((line+scroll_y) mod 256)/8, and map_col = (scroll_x/8 + tile number) mod 32, so both coordinates wrap.
- R3: With `data_unsigned`=1, the tile index i is unsigned. Row r of the tile has its low bit-plane byte at 0x8000+16*i+2*r and its high bit-plane byte at the next address, where r = (line+scroll_y) mod 8.
- R4: With `data_unsigned`=0, the index is a two's complement value. Index 0 lies at 0x9000, so 0x80 maps to 0x8800 and 0x7F maps to 0x97F0. The row offsets are the same as in R3.
- R5: A pixel's colour c is {high-plane bit, low-plane bit}, and the leftmost pixel comes from bit 7. The output `pix_shade` equals palette bits [2c+1:2c].
- R6: The first (scroll_x mod 8) pixels of a line are dropped. Exactly 160 pixels are then delivered, and the first one belongs to background x = scroll_x. After the 160th pixel is consumed, `line_done` is 1 and `pix_valid` is 0 until the next `line_start`.
- R7: While `pix_valid`=1 and `pix_ready`=0, `pix_valid` stays 1 and `pix_shade` stays unchanged on the next cycle.
- R8: Line number, scrolls, selects and palette are sampled only at `line_start`. Changing them during a line has no effect on that line's pixels.
- R9: A `line_start` at any time, even mid-line or in a cycle where a pixel is being consumed, restarts the line. In the next cycle `pix_valid` and `line_done` are 0, and the next pixel delivered is pixel 0 of the new line.
- R10: Every read has `vram_rd`=1 and an address in 0x8000–0x9FFF. Read data is taken from `vram_data` one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that samples the configuration and starts a line |
| line_num | input | 8 | Scanline number |
| scroll_x | input | 8 | Horizontal scroll |
| scroll_y | input | 8 | Vertical scroll |
| map_hi_sel | input | 1 | Tile map select: 0 = 0x9800, 1 = 0x9C00 |
| data_unsigned | input | 1 | Tile data mode: 1 = unsigned from 0x8000, 0 = signed around 0x9000 |
| palette | input | 8 | Four 2-bit shades indexed by colour |
| vram_rd | output | 1 | Read strobe |
| vram_addr | output | 16 | Read address |
| vram_data | input | 8 | Read data, valid the cycle after the address |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_shade | output | 2 | Palette-mapped shade |
| line_done | output | 1 | All 160 pixels of the line delivered |

## Verification
Two events can fall in the same cycle: a restarting `line_start` and the consumption of a pixel. The bench provokes this by holding `pix_ready` high and pulsing `line_start` in a cycle where `pix_valid` is high. That pixel must match the old line, and the pixel stream must then start over at pixel 0 under the new configuration. Dropped scroll pixels and stalls from a pseudo-random `pix_ready` also overlap. Every consumed pixel is judged against a behavioural model of the plane, and the bench checks how many pixels were delivered when `line_done` rises.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int TILE_W   = 8;
  localparam int COORD_W  = 8;
  localparam int MAP_IDX_W = 5;
  localparam int ADDR_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP,
    ST_LO,
    ST_HI,
    ST_CAP,
    ST_SHIFT,
    ST_DONE
  } fetch_state_t;

  typedef struct packed {
    logic [COORD_W-1:0]   plane_y;
    logic [MAP_IDX_W-1:0] x_tile;
    logic                 map_hi;
    logic                 uns;
    logic [7:0]           pal;
  } line_cfg_t;
endpackage

// File: rtl/tpf_addr.sv
module tpf_addr
  import tpf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [COORD_W-1:0]   plane_y,
  input  logic [MAP_IDX_W-1:0] x_tile,
  input  logic [MAP_IDX_W-1:0] tile_num,
  input  logic                 map_hi,
  input  logic                 uns,
  input  logic [7:0]           tile_idx,
  input  logic                 plane_hi,
  output logic [AW-1:0]        map_addr,
  output logic [AW-1:0]        data_addr
);
  localparam logic [AW-1:0] MAP0_BASE = AW'(16'h9800);
  localparam logic [AW-1:0] MAP1_BASE = AW'(16'h9C00);
  localparam logic [AW-1:0] UNS_BASE  = AW'(16'h8000);
  localparam logic [AW-1:0] SGN_BASE  = AW'(16'h9000);

  logic [MAP_IDX_W-1:0] col;
  logic [AW-1:0]        tile_off;
  logic [AW-1:0]        row_off;

  always_comb begin
    col      = x_tile + tile_num;
    map_addr = (map_hi ? MAP1_BASE : MAP0_BASE)
             | AW'({plane_y[COORD_W-1:3], col});
    if (uns)
      tile_off = UNS_BASE + AW'({tile_idx, 4'b0000});
    else
      tile_off = SGN_BASE + AW'({{4{tile_idx[7]}}, tile_idx, 4'b0000});
    row_off   = AW'({plane_y[2:0], plane_hi});
    data_addr = tile_off + row_off;
  end
endmodule

// File: rtl/tpf_shifter.sv
module tpf_shifter
  import tpf_pkg::*;
#(
  parameter int W = TILE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] lo_byte,
  input  logic [W-1:0] hi_byte,
  output logic [1:0]   color
);
  logic [W-1:0] plane_in [2];
  assign plane_in[0] = lo_byte;
  assign plane_in[1] = hi_byte;

  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [W-1:0] sr;
    always_ff @(posedge clk) begin
      if (!rst_n)
        sr <= '0;
      else if (load)
        sr <= plane_in[p];
      else if (shift)
        sr <= {sr[W-2:0], 1'b0};
    end
    assign color[p] = sr[W-1];
  end
endmodule

// File: rtl/tpf_palette.sv
module tpf_palette (
  input  logic [7:0] pal,
  input  logic [1:0] color,
  output logic [1:0] shade
);
  always_comb shade = pal[2*color +: 2];
endmodule

// File: rtl/tile_pixel_fetcher.sv
module tile_pixel_fetcher
  import tpf_pkg::*;
#(
  parameter int LINE_PIXELS = 160,
  parameter int AW          = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [7:0]    line_num,
  input  logic [7:0]    scroll_x,
  input  logic [7:0]    scroll_y,
  input  logic          map_hi_sel,
  input  logic          data_unsigned,
  input  logic [7:0]    palette,
  output logic          vram_rd,
  output logic [AW-1:0] vram_addr,
  input  logic [7:0]    vram_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [1:0]    pix_shade,
  output logic          line_done
);
  localparam int PCW  = $clog2(LINE_PIXELS + 1);
  localparam int BCW  = $clog2(TILE_W);
  localparam logic [PCW-1:0] LAST_PIX = PCW'(LINE_PIXELS - 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(TILE_W - 1);

  fetch_state_t         state;
  line_cfg_t            cfg;
  logic [MAP_IDX_W-1:0] tile_num;
  logic [7:0]           idx_r;
  logic [7:0]           lo_r;
  logic [PCW-1:0]       pix_cnt;
  logic [BCW-1:0]       bit_cnt;
  logic [BCW-1:0]       drop_cnt;

  logic                 dropping;
  logic                 step;
  logic                 sh_load;
  logic [7:0]           idx_sel;
  logic [AW-1:0]        map_addr;
  logic [AW-1:0]        data_addr;
  logic [1:0]           color;

  always_comb begin
    dropping  = (state == ST_SHIFT) && (drop_cnt != '0);
    pix_valid = (state == ST_SHIFT) && (drop_cnt == '0);
    step      = dropping || (pix_valid && pix_ready);
    sh_load   = (state == ST_CAP);
    line_done = (state == ST_DONE);
    idx_sel   = (state == ST_LO) ? vram_data : idx_r;
    vram_rd   = (state == ST_MAP) || (state == ST_LO) || (state == ST_HI);
    vram_addr = (state == ST_MAP) ? map_addr :
                vram_rd           ? data_addr : '0;
  end

  tpf_addr #(.AW(AW)) addr_i (
    .plane_y   (cfg.plane_y),
    .x_tile    (cfg.x_tile),
    .tile_num  (tile_num),
    .map_hi    (cfg.map_hi),
    .uns       (cfg.uns),
    .tile_idx  (idx_sel),
    .plane_hi  (state == ST_HI),
    .map_addr  (map_addr),
    .data_addr (data_addr)
  );

  tpf_shifter #(.W(TILE_W)) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .shift   (step),
    .lo_byte (lo_r),
    .hi_byte (vram_data),
    .color   (color)
  );

  tpf_palette palette_i (
    .pal   (cfg.pal),
    .color (color),
    .shade (pix_shade)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg      <= '0;
      tile_num <= '0;
      idx_r    <= '0;
      lo_r     <= '0;
      pix_cnt  <= '0;
      bit_cnt  <= '0;
      drop_cnt <= '0;
    end else if (line_start) begin
      state       <= ST_MAP;
      cfg.plane_y <= line_num + scroll_y;
      cfg.x_tile  <= scroll_x[7:3];
      cfg.map_hi  <= map_hi_sel;
      cfg.uns     <= data_unsigned;
      cfg.pal     <= palette;
      tile_num    <= '0;
      pix_cnt     <= '0;
      bit_cnt     <= '0;
      drop_cnt    <= scroll_x[BCW-1:0];
    end else begin
      unique case (state)
        ST_MAP: state <= ST_LO;
        ST_LO: begin
          idx_r <= vram_data;
          state <= ST_HI;
        end
        ST_HI: begin
          lo_r  <= vram_data;
          state <= ST_CAP;
        end
        ST_CAP: begin
          bit_cnt <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (step) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (dropping)
              drop_cnt <= drop_cnt - 1'b1;
            else
              pix_cnt <= pix_cnt + 1'b1;
            if (!dropping && pix_cnt == LAST_PIX) begin
              state <= ST_DONE;
            end else if (bit_cnt == LAST_BIT) begin
              tile_num <= tile_num + 1'b1;
              state    <= ST_MAP;
            end
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
  parameter int LINE_PIXELS = 160,
  parameter int AW          = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          vram_rd,
  input logic [AW-1:0] vram_addr,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [1:0]    pix_shade,
  input logic          line_done
);
  localparam int CW = $clog2(LINE_PIXELS + 2);
  logic [CW-1:0] taken;

  always_ff @(posedge clk) begin
    if (!rst_n)
      taken <= '0;
    else if (line_start)
      taken <= '0;
    else if (pix_valid && pix_ready)
      taken <= taken + 1'b1;
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && !line_start) |=> (pix_valid && $stable(pix_shade)));

  // R10
  vram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> (vram_addr >= AW'(16'h8000) && vram_addr <= AW'(16'h9FFF)));

  // R6
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (taken == CW'(LINE_PIXELS) && !pix_valid));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken <= CW'(LINE_PIXELS));

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (!pix_valid && !line_done));
endmodule

bind tile_pixel_fetcher tpf_checker #(.LINE_PIXELS(LINE_PIXELS), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .vram_rd    (vram_rd),
  .vram_addr  (vram_addr),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_shade  (pix_shade),
  .line_done  (line_done)
);

// File: tb/tile_pixel_fetcher_tb_top.sv
`timescale 1ns/1ps
module tile_pixel_fetcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [7:0]  line_num = '0;
  logic [7:0]  scroll_x = '0;
  logic [7:0]  scroll_y = '0;
  logic        map_hi_sel = 1'b0;
  logic        data_unsigned = 1'b1;
  logic [7:0]  palette = 8'hE4;
  logic        vram_rd;
  logic [15:0] vram_addr;
  logic [7:0]  vram_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic [1:0]  pix_shade;
  logic        line_done;

  always #10 clk = ~clk;

  tile_pixel_fetcher dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .map_hi_sel(map_hi_sel),
    .data_unsigned(data_unsigned), .palette(palette), .vram_rd(vram_rd),
    .vram_addr(vram_addr), .vram_data(vram_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_shade(pix_shade), .line_done(line_done)
  );

  int vectors = 0;
  int fails = 0;
  int seed = 5;
  string tag = "R6";
  int rdy_mode = 0;
  int lf = 1;
  int acc = 0;
  bit done_seen = 1'b1;
  bit prev_stall = 1'b0;
  logic [1:0] prev_shade = '0;
  int p_line, p_sx, p_sy, p_map, p_uns, p_pal;
  int c_line, c_sx, c_sy, c_map, c_uns, c_pal;

  function automatic int vmem(int a);
    return ((a * 37) ^ (a >> 3) ^ seed) & 255;
  endfunction

  function automatic int exp_shade(int k);
    int bx, by, ma, idx, ti, base, lo, hi, b, c;
    bx = (c_sx + k) & 255;
    by = (c_line + c_sy) & 255;
    ma = (c_map != 0 ? 'h9C00 : 'h9800) + (by >> 3) * 32 + (bx >> 3);
    idx = vmem(ma);
    if (c_uns != 0) base = 'h8000 + idx * 16;
    else begin
      ti = (idx >= 128) ? idx - 256 : idx;
      base = 'h9000 + ti * 16;
    end
    lo = vmem(base + (by & 7) * 2);
    hi = vmem(base + (by & 7) * 2 + 1);
    b = 7 - (bx & 7);
    c = (((hi >> b) & 1) << 1) | ((lo >> b) & 1);
    return (c_pal >> (2 * c)) & 3;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // memory responder: data one cycle after the address
  always @(posedge clk) begin
    if (vram_rd) vram_data <= 8'(vmem(int'(vram_addr)));
  end

  // reference model and comparison, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_mode != 0) begin
        lf = lf * 1103515245 + 12345;
        pix_ready = lf[17] | lf[21];
      end else begin
        pix_ready = 1'b1;
      end
      if (prev_stall) begin
        check(pix_valid === 1'b1 && pix_shade === prev_shade, "R7",
              int'(pix_shade), int'(prev_shade));
      end
      prev_stall = pix_valid && !pix_ready && !line_start;
      prev_shade = pix_shade;
      if (vram_rd) begin
        check(vram_addr >= 16'h8000 && vram_addr <= 16'h9FFF, "R10",
              int'(vram_addr), 'h8000);
      end
      if (pix_valid && pix_ready) begin
        if (acc >= 160) check(1'b0, "R6", acc + 1, 160);
        else check(int'(pix_shade) == exp_shade(acc), tag, int'(pix_shade), exp_shade(acc));
        acc++;
      end
      if (line_done && !done_seen) begin
        check(acc == 160 && !pix_valid, "R6", acc, 160);
        done_seen = 1'b1;
      end
      if (line_start) begin
        c_line = p_line; c_sx = p_sx; c_sy = p_sy;
        c_map = p_map; c_uns = p_uns; c_pal = p_pal;
        acc = 0;
        done_seen = 1'b0;
        prev_stall = 1'b0;
      end
    end
  end

  // called at posedge + 2
  task automatic start_line(int l, int sx, int sy, int m, int u, int p);
    line_num = 8'(l); scroll_x = 8'(sx); scroll_y = 8'(sy);
    map_hi_sel = m[0]; data_unsigned = u[0]; palette = 8'(p);
    p_line = l; p_sx = sx; p_sy = sy; p_map = m; p_uns = u; p_pal = p;
    line_start = 1'b1;
    @(posedge clk); #2;
    line_start = 1'b0;
  endtask

  task automatic sync();
    @(posedge clk); #2;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!line_done && guard < 5000) begin
      sync();
      guard++;
    end
    check(line_done === 1'b1, "R6", int'(line_done), 1);
    sync();
  endtask

  task automatic wait_acc(int n);
    int guard = 0;
    while (acc < n && guard < 5000) begin
      sync();
      guard++;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) sync();
    // R1: idle after reset
    check(pix_valid === 1'b0, "R1", int'(pix_valid), 0);
    check(vram_rd === 1'b0, "R1", int'(vram_rd), 0);
    check(line_done === 1'b0, "R1", int'(line_done), 0);

    // R3: unsigned data, map 0, no scroll, identity palette
    tag = "R3"; rdy_mode = 0; seed = 5;
    start_line(0, 0, 0, 0, 1, 'hE4);
    wait_done();

    // R4: signed data, fine scroll 3, stalls
    tag = "R4"; rdy_mode = 1; seed = 91;
    start_line(10, 3, 0, 0, 0, 'hE4);
    wait_done();

    // R2: map 1, wrap in both directions
    tag = "R2"; rdy_mode = 1; seed = 17;
    start_line(20, 'hFD, 'hF8, 1, 1, 'hE4);
    wait_done();
    start_line(143, 'hC7, 'h23, 1, 0, 'h1B);
    wait_done();

    // R5: palette remaps
    tag = "R5"; rdy_mode = 0; seed = 200;
    start_line(77, 0, 5, 0, 1, 'h1B);
    wait_done();
    start_line(78, 8, 5, 1, 0, 'hA5);
    wait_done();

    // R6: maximum fine scroll, heavy stalls
    tag = "R6"; rdy_mode = 1; seed = 33;
    start_line(1, 7, 0, 0, 1, 'hE4);
    wait_done();

    // R7: stall pattern with scroll 5
    tag = "R7"; rdy_mode = 1; seed = 44;
    start_line(60, 5, 9, 1, 1, 'h6C);
    wait_done();

    // R8: inputs changed after line start are ignored
    tag = "R8"; rdy_mode = 1; seed = 58;
    start_line(33, 2, 4, 0, 0, 'hD2);
    line_num = 8'd99; scroll_x = 8'd6; scroll_y = 8'd70;
    map_hi_sel = 1'b1; data_unsigned = 1'b1; palette = 8'h00;
    wait_done();

    // R9: mid-line restart
    tag = "R9"; rdy_mode = 1; seed = 71;
    start_line(40, 4, 0, 0, 1, 'hE4);
    wait_acc(50);
    start_line(41, 1, 3, 1, 0, 'h39);
    check(line_done === 1'b0 && pix_valid === 1'b0, "R9", int'(pix_valid), 0);
    wait_done();

    // R9: restart in the same cycle as a pixel hand-over
    rdy_mode = 0;
    start_line(50, 6, 2, 0, 0, 'hE4);
    wait_acc(30);
    while (!pix_valid) sync();
    start_line(51, 2, 2, 1, 1, 'h4E);
    check(pix_valid === 1'b0 && line_done === 1'b0, "R9", int'(pix_valid), 0);
    wait_done();

    // R9: restart after a completed line
    start_line(52, 0, 0, 0, 1, 'hE4);
    check(line_done === 1'b0, "R9", int'(line_done), 0);
    wait_done();

    repeat (4) sync();
    finish_run();
  end
endmodule